// File: doc/BRIEF.md
# Serial Audio Interrupt Status Unit

This block collects the events and conditions of a serial audio port into one 16-bit status word and turns them into a single interrupt line. Some status bits are live levels that follow the transmit and receive buffers from cycle to cycle. Others are sticky error and progress flags. A sticky flag is set by a one-cycle pulse from the datapath and stays set until software clears it.

Software reaches three registers through a small port. The port has one address bus that both reads and writes use, a write strobe, write data and combinational read data. The enable register selects which of the low eleven status bits may raise the interrupt. The status register is read-only. The clear register is write-1-to-clear and acts only on the sticky range. The interrupt line is high whenever an enabled status bit is high.

Top module: `sai_irq_status`

## Requirements
- R1: After a synchronous reset, the enable register reads 0, every sticky flag (status bits 11:3) reads 0, and `irq_o` is low.
- R2: `event_i[k]` sets status bit k+3 on the next clock edge. The event order is: 0 end of transfer, 1 transmit filled, 2 underrun, 3 overrun, 4 CRC error, 5 frame error, 6 mode fault, 7 reload, 8 suspended. A set flag holds until it is cleared.
- R3: A write to the clear register (address 2) with bit b=1, where b is in 11:3, clears status bit b at that clock edge. Bits written as 0 leave their flags unchanged.
- R4: Clear-register bits 2:0 and 15:12 have no effect on the status word.
- R5: If an event and a clear for the same flag arrive in the same cycle, the flag ends up set.
- R6: The live bits follow their inputs in the same cycle. Bit 0 is receive packet available, bit 1 is transmit space available, bit 2 is duplex packet, bit 12 is transmit complete, bits 14:13 are the receive packing level and bit 15 is received word not empty.
- R7: The enable register (address 0) stores write-data bits 10:0. Bits 15:11 always read as 0.
- R8: `irq_o` is high exactly when some bit in 10:0 is set in both the status word and the enable register.
- R9: Status bits 15:11 never cause `irq_o` to go high, even if every enable bit was written as 1.
- R10: The clear register reads as 0. Address 3 reads as 0. Writes to the status register (address 1) and to address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_pkt_avail_i | input | 1 | Live: receive packet available (status bit 0) |
| tx_space_avail_i | input | 1 | Live: transmit space available (status bit 1) |
| duplex_pkt_i | input | 1 | Live: duplex packet (status bit 2) |
| tx_complete_i | input | 1 | Live: transmit complete (status bit 12) |
| rx_pack_lvl_i | input | 2 | Live: receive packing level (status bits 14:13) |
| rx_nonempty_i | input | 1 | Live: received word not empty (status bit 15) |
| event_i | input | 9 | One-cycle event pulses for sticky status bits 11:3 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 enable, 1 status, 2 clear, 3 unused |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Combinational read data for `reg_addr_i` |
| irq_o | output | 1 | Interrupt request |

## Verification
Assertions check on every cycle that an event pulse leaves its flag set on the next cycle, including when a clear arrives at the same time. They also check that a clear with no matching event empties its flag, that an idle cycle leaves the flags untouched, that an all-zero enable keeps the interrupt low, and that the reserved read fields stay zero. The bench scenarios cover the rest. They sweep every live-input pattern and clear each sticky flag one at a time with the others still set. They also show that clear bits outside the sticky range and writes to the status address have no effect, and they walk each enable bit against its own source and against all the other sources.

// File: rtl/sai_irq_pkg.sv
package sai_irq_pkg;

    localparam int STAT_W = 16;
    localparam int EN_W   = 11;
    localparam int STK_LO = 3;
    localparam int STK_HI = 11;
    localparam int STK_W  = STK_HI - STK_LO + 1;
    localparam int LIVE_W = STK_LO;
    localparam int PACK_W = 2;
    localparam int ADDR_W = 2;

    localparam logic [STAT_W-1:0] ENABLE_MASK = STAT_W'((1 << EN_W) - 1);

    typedef enum logic [ADDR_W-1:0] {
        SEL_ENABLE = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_CLEAR  = 2'd2,
        SEL_SPARE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              rx_nonempty;
        logic [PACK_W-1:0] rx_pack_lvl;
        logic              tx_complete;
        logic [STK_W-1:0]  sticky;
        logic [LIVE_W-1:0] live;
    } status_t;

    typedef struct packed {
        logic              wr;
        reg_sel_e          sel;
        logic [STAT_W-1:0] data;
    } reg_req_t;

    function automatic logic [STK_W-1:0] sticky_field(input logic [STAT_W-1:0] w);
        return w[STK_HI:STK_LO];
    endfunction

endpackage

// File: rtl/sai_irq_sticky.sv
module sai_irq_sticky #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flags_o
);
    logic [W-1:0] flag_q;

    for (genvar i = 0; i < W; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flag_q[i] <= 1'b0;
            else if (set_i[i])
                flag_q[i] <= 1'b1;
            else if (clr_i[i])
                flag_q[i] <= 1'b0;
        end
    end

    assign flags_o = flag_q;

    // Event pulse always leaves its flag set, even against a clear (R2, R5)
    assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));

    // Clear without a matching event empties the flag (R3)
    assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (clr_i != '0) |=> ((flags_o & $past(clr_i) & ~$past(set_i)) == '0));

    // Flags hold when neither set nor clear is present (R2)
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (set_i == '0 && clr_i == '0) |=> $stable(flags_o));

endmodule

// File: rtl/sai_irq_regs.sv
module sai_irq_regs
    import sai_irq_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  reg_req_t                req_i,
    input  status_t                 status_i,
    output logic [STAT_W-1:0]       en_o,
    output logic [STK_W-1:0]        clr_o,
    output logic [STAT_W-1:0]       rdata_o
);
    logic [STAT_W-1:0] en_q;

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (req_i.wr && req_i.sel == SEL_ENABLE)
            en_q <= req_i.data & ENABLE_MASK;
    end

    always_comb begin
        clr_o = '0;
        if (req_i.wr && req_i.sel == SEL_CLEAR)
            clr_o = sticky_field(req_i.data);
    end

    always_comb begin
        unique case (req_i.sel)
            SEL_ENABLE: rdata_o = en_q;
            SEL_STATUS: rdata_o = status_i;
            default:    rdata_o = '0;
        endcase
    end

    assign en_o = en_q;

    // Reset empties the enable register (R1)
    assert_reset_enable_R1: assert property (@(posedge clk)
        rst |=> (en_o == '0));

    // Enable bits above the interrupt range stay zero (R7, R9)
    assert_enable_high_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (en_o & ~ENABLE_MASK) == '0);

    // Clear register reads back zero (R10)
    assert_clear_reads_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (req_i.sel == SEL_CLEAR) |-> (rdata_o == '0));

endmodule

// File: rtl/sai_irq_combine.sv
module sai_irq_combine
    import sai_irq_pkg::*;
(
    input  status_t           status_i,
    input  logic [STAT_W-1:0] en_i,
    output logic              irq_o
);
    logic [STAT_W-1:0] src;
    logic [STAT_W-1:0] hit;

    assign src = status_i;

    for (genvar b = 0; b < STAT_W; b++) begin : g_src
        if (b < EN_W) begin : g_live
            assign hit[b] = src[b] & en_i[b];
        end else begin : g_off
            assign hit[b] = 1'b0 & en_i[b] & src[b];
        end
    end

    assign irq_o = |hit;

endmodule

// File: rtl/sai_irq_status.sv
module sai_irq_status
    import sai_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_pkt_avail_i,
    input  logic                tx_space_avail_i,
    input  logic                duplex_pkt_i,
    input  logic                tx_complete_i,
    input  logic [1:0]          rx_pack_lvl_i,
    input  logic                rx_nonempty_i,
    input  logic [8:0]          event_i,
    input  logic                reg_wr_i,
    input  logic [1:0]          reg_addr_i,
    input  logic [15:0]         reg_wdata_i,
    output logic [15:0]         reg_rdata_o,
    output logic                irq_o
);
    status_t           status;
    reg_req_t          req;
    logic [STK_W-1:0]  sticky;
    logic [STK_W-1:0]  clr;
    logic [STAT_W-1:0] en;

    assign req.wr   = reg_wr_i;
    assign req.sel  = reg_sel_e'(reg_addr_i);
    assign req.data = reg_wdata_i;

    assign status.rx_nonempty = rx_nonempty_i;
    assign status.rx_pack_lvl = rx_pack_lvl_i;
    assign status.tx_complete = tx_complete_i;
    assign status.sticky      = sticky;
    assign status.live        = {duplex_pkt_i, tx_space_avail_i, rx_pkt_avail_i};

    sai_irq_sticky #(.W(STK_W)) sticky_i (
        .clk     (clk),
        .rst     (rst),
        .set_i   (event_i),
        .clr_i   (clr),
        .flags_o (sticky)
    );

    sai_irq_regs regs_i (
        .clk      (clk),
        .rst      (rst),
        .req_i    (req),
        .status_i (status),
        .en_o     (en),
        .clr_o    (clr),
        .rdata_o  (reg_rdata_o)
    );

    sai_irq_combine combine_i (
        .status_i (status),
        .en_i     (en),
        .irq_o    (irq_o)
    );

    // No enabled source means no interrupt (R8)
    assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
        (en == '0) |-> !irq_o);

    // Reset empties the sticky flags (R1)
    assert_reset_sticky_R1: assert property (@(posedge clk)
        rst |=> (sticky == '0));

    // Spare address reads zero (R10)
    assert_spare_reads_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_addr_i == 2'd3) |-> (reg_rdata_o == '0));

endmodule

// File: tb/sai_irq_status_tb.sv
module sai_irq_status_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_pkt_avail_i = 0, tx_space_avail_i = 0, duplex_pkt_i = 0;
    logic        tx_complete_i = 0, rx_nonempty_i = 0;
    logic [1:0]  rx_pack_lvl_i = 0;
    logic [8:0]  event_i = 0;
    logic        reg_wr_i = 0;
    logic [1:0]  reg_addr_i = 0;
    logic [15:0] reg_wdata_i = 0;
    logic [15:0] reg_rdata_o;
    logic        irq_o;

    int n_run = 0;
    int n_fail = 0;
    logic [8:0]  exp_stk = 0;
    logic [15:0] exp_en = 0;

    always #2 clk = ~clk;

    sai_irq_status dut_i (.*);

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        event_i  = '0;
        reg_wr_i = 1'b0;
    endtask

    task automatic set_live(input logic [6:0] v);
        {rx_nonempty_i, rx_pack_lvl_i, tx_complete_i, duplex_pkt_i, tx_space_avail_i, rx_pkt_avail_i} = v;
    endtask

    function automatic logic [15:0] exp_status();
        return {rx_nonempty_i, rx_pack_lvl_i, tx_complete_i, exp_stk,
                duplex_pkt_i, tx_space_avail_i, rx_pkt_avail_i};
    endfunction

    function automatic logic exp_irq();
        return |(exp_status() & exp_en & 16'h07FF);
    endfunction

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        tick();
        if (a == 2'd0) exp_en = d & 16'h07FF;
        if (a == 2'd2) exp_stk = exp_stk & ~d[11:3];
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        reg_addr_i = a;
        #0.5;
        v = reg_rdata_o;
    endtask

    task automatic fire(input logic [8:0] m);
        event_i = m;
        tick();
        exp_stk = exp_stk | m;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        rd(2'd0, v); chk("R1 enable", v, 16'h0);
        rd(2'd1, v); chk("R1 status", v, 16'h0);
        chk("R1 irq", {15'h0, irq_o}, 16'h0);

        // R6: sweep all live-input patterns
        for (int p = 0; p < 128; p++) begin
            set_live(p[6:0]);
            rd(2'd1, v); chk("R6 live", v, exp_status());
            chk("R8 irq off", {15'h0, irq_o}, 16'h0);
        end
        set_live(7'h0);

        // R2: each event sets its flag and holds
        for (int k = 0; k < 9; k++) begin
            fire(9'(1 << k));
            rd(2'd1, v); chk("R2 set", v, exp_status());
            tick(); tick();
            rd(2'd1, v); chk("R2 hold", v, exp_status());
            wr(2'd2, 16'hFFFF);
            rd(2'd1, v); chk("R3 clear all", v, exp_status());
        end

        // R3/R4: one-hot clear across all 16 positions with all flags set
        set_live(7'h7F);
        for (int b = 0; b < 16; b++) begin
            fire(9'h1FF);
            wr(2'd2, 16'(1 << b));
            rd(2'd1, v);
            chk((b >= 3 && b <= 11) ? "R3 one-hot" : "R4 outside", v, exp_status());
        end
        // R3: zero write has no effect
        fire(9'h1FF);
        wr(2'd2, 16'h0);
        rd(2'd1, v); chk("R3 zero write", v, exp_status());
        wr(2'd2, 16'hFFFF);
        set_live(7'h0);

        // R5: set wins over clear in same cycle
        for (int k = 0; k < 9; k++) begin
            event_i = 9'(1 << k);
            reg_wr_i = 1'b1; reg_addr_i = 2'd2; reg_wdata_i = 16'hFFFF;
            tick();
            exp_stk = 9'(1 << k);
            rd(2'd1, v); chk("R5 set wins", v, exp_status());
        end
        wr(2'd2, 16'hFFFF);

        // R7: enable read-back
        wr(2'd0, 16'hFFFF); rd(2'd0, v); chk("R7 all ones", v, 16'h07FF);
        wr(2'd0, 16'hA5A5); rd(2'd0, v); chk("R7 pattern", v, 16'h05A5);
        wr(2'd0, 16'h0);    rd(2'd0, v); chk("R7 zero", v, 16'h0);

        // R8: each enable bit against its own source and against others
        for (int b = 0; b < 11; b++) begin
            wr(2'd0, 16'(1 << b));
            // others active, own inactive
            set_live((b < 3) ? (7'h7F & ~7'(1 << b)) : 7'h7F);
            fire(9'h1FF & ((b >= 3) ? ~9'(1 << (b - 3)) : 9'h1FF));
            rd(2'd1, v);
            chk("R8 other src", {15'h0, irq_o}, {15'h0, exp_irq()});
            chk("R8 other src low", {15'h0, irq_o}, 16'h0);
            // own source active
            if (b < 3) set_live(7'h7F);
            else fire(9'(1 << (b - 3)));
            #0.5;
            chk("R8 own src", {15'h0, irq_o}, 16'h1);
            wr(2'd2, 16'hFFFF);
            set_live(7'h0);
            #0.5;
            chk("R8 released", {15'h0, irq_o}, 16'h0);
        end

        // R9: only high bits active with all enables written
        wr(2'd0, 16'hFFFF);
        set_live(7'h78);
        fire(9'h100);
        #0.5;
        chk("R9 high bits", {15'h0, irq_o}, 16'h0);

        // R10: clear/spare read zero, status/spare writes ignored
        rd(2'd2, v); chk("R10 clear reads 0", v, 16'h0);
        rd(2'd3, v); chk("R10 spare reads 0", v, 16'h0);
        wr(2'd1, 16'h0000);
        rd(2'd1, v); chk("R10 status write", v, exp_status());
        wr(2'd3, 16'hFFFF);
        rd(2'd1, v); chk("R10 spare write status", v, exp_status());
        rd(2'd0, v); chk("R10 spare write enable", v, 16'h07FF);

        // R1: reset again mid-run
        rst = 1'b1; tick(); rst = 1'b0;
        exp_stk = 0; exp_en = 0;
        rd(2'd0, v); chk("R1 re-reset enable", v, 16'h0);
        rd(2'd1, v); chk("R1 re-reset status", v, exp_status());

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule